// File: doc/BRIEF.md
# Mirror Block Operation Decoder

This block turns the block-control fields of each row cycle into per-block action masks for a mirror array of 16 blocks. The fields are a two-bit operation mode, a four-bit block address and a pairing select. The masks are memory clear, mirror clocking pulse and park. A row-cycle start strobe samples the fields. One clock later the block presents the registered masks together with a single-cycle issue pulse.

The block also enforces the array's sequencing rules:

- A clear is refused while a write to a different block is in progress.
- On the 15-block array variant, block 15 is treated as absent.
- On the 15-block variant, every accepted clear must be followed by two no-op row cycles.
- The pairing select, which chooses between pairs and groups of four for grouped pulses, takes effect only after it has settled.

A request that breaks a rule is dropped and latches a sticky error flag.

Top module: `mirror_blk_decoder`

## Requirements
- R1: Mode 2'b00 is a no-op for any address: the issue pulse appears and all three masks are zero.
- R2: Mode 2'b01 clears one block. Bit `blk_addr` of `clr_mask` is set, and no other bit of any mask is set.
- R3: Mode 2'b10 sends a clocking pulse to one block. Bit `blk_addr` of `mcp_mask` is set.
- R4: Mode 2'b11 with address bit 3 at 0 and effective pairing 0 pulses the pair of blocks 2n and 2n+1, where n = `blk_addr[2:0]`.
- R5: Mode 2'b11 with address bit 3 at 0 and effective pairing 1 pulses the four blocks 4n to 4n+3, where n = `blk_addr[2:1]`. Address bit 0 is ignored.
- R6: Mode 2'b11 with address 2'b10 in bits 3:2 sets every bit of `mcp_mask` (global). Address 2'b11 in bits 3:2 sets every bit of `park_mask`. Both hold whatever the pairing.
- R7: Outputs are registered. Issue and the masks reflect a strobe sampled at clock edge k during the cycle after edge k only. At all other times the masks are zero.
- R8: While `fifteen_blk` is 1, bit 15 of every mask is zero.
- R9: A clear accepted while `fifteen_blk` is 1 opens a window of two row cycles. Any request other than a no-op inside that window is dropped. Every row cycle shortens the window, including a dropped one. On the 16-block variant no window is opened.
- R10: A clear with `write_busy` at 1 and `write_blk` different from `blk_addr` is dropped. A clear of the block being written is accepted. A pulse request is accepted during any write.
- R11: A new pairing value is used only after it has been sampled at two consecutive strobes. It governs decode from the third strobe on. After reset the effective pairing is 0.
- R12: A dropped request gives all-zero masks for that row cycle and sets `rule_err`. `rule_err` stays at 1 until reset. Reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| row_start | input | 1 | Row-cycle start strobe, samples the control fields |
| blk_mode | input | 2 | Operation mode |
| blk_addr | input | 4 | Block address |
| pair_sel | input | 1 | Pairing select: 0 for pairs, 1 for groups of four |
| write_busy | input | 1 | A row write is in progress |
| write_blk | input | 4 | Block the current row write targets |
| fifteen_blk | input | 1 | 1 selects the 15-block array variant |
| clr_mask | output | 16 | Blocks to clear |
| mcp_mask | output | 16 | Blocks to receive a clocking pulse |
| park_mask | output | 16 | Blocks to park |
| issue | output | 1 | One-clock pulse per row cycle |
| rule_err | output | 1 | Sticky rule-violation flag |

## Verification
Every result is due on the falling edge that follows the rising edge that samples a strobe. This holds for the masks, the issue pulse and the error flag, since each sits one register behind the strobe. The driver raises the strobe on a falling edge and queues the expected masks and flag. The monitor compares the queue entry at the next falling edge, where `issue` must be high. On every other falling edge the monitor requires zero masks. Just after that edge the driver confirms the queue has drained, so a late or missing pulse is caught. Pairing and no-op window checks count strobes, not clocks, so the expected values follow the order in which row cycles are issued.

// File: rtl/mirror_blk_decoder.sv
module mirror_blk_decoder #(
  parameter int NOP_CYCLES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        row_start,
  input  logic [1:0]  blk_mode,
  input  logic [3:0]  blk_addr,
  input  logic        pair_sel,
  input  logic        write_busy,
  input  logic [3:0]  write_blk,
  input  logic        fifteen_blk,
  output logic [15:0] clr_mask,
  output logic [15:0] mcp_mask,
  output logic [15:0] park_mask,
  output logic        issue,
  output logic        rule_err
);
  localparam int CW = $clog2(NOP_CYCLES + 1);

  logic [CW-1:0] nop_left;
  logic          pair_cand, pair_pend, pair_eff;
  logic [15:0]   one_m, dual_m, quad_m, live_m;
  logic [15:0]   d_clr, d_mcp, d_park;
  logic          conflict, drop;

  assign one_m    = 16'h0001 << blk_addr;
  assign dual_m   = 16'h0003 << {blk_addr[2:0], 1'b0};
  assign quad_m   = 16'h000F << {blk_addr[2:1], 2'b00};
  assign live_m   = fifteen_blk ? 16'h7FFF : 16'hFFFF;
  assign conflict = (blk_mode == 2'b01) && write_busy && (write_blk != blk_addr);
  assign drop     = conflict || ((nop_left != '0) && (blk_mode != 2'b00));

  always_comb begin
    d_clr  = '0;
    d_mcp  = '0;
    d_park = '0;
    if (!drop) begin
      case (blk_mode)
        2'b01: d_clr = one_m & live_m;
        2'b10: d_mcp = one_m & live_m;
        2'b11: begin
          if (blk_addr[3]) begin
            if (blk_addr[2]) d_park = live_m;
            else             d_mcp  = live_m;
          end else begin
            d_mcp = (pair_eff ? quad_m : dual_m) & live_m;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clr_mask  <= '0;
      mcp_mask  <= '0;
      park_mask <= '0;
      issue     <= 1'b0;
      rule_err  <= 1'b0;
      nop_left  <= '0;
      pair_cand <= 1'b0;
      pair_pend <= 1'b0;
      pair_eff  <= 1'b0;
    end else begin
      issue     <= row_start;
      clr_mask  <= row_start ? d_clr  : '0;
      mcp_mask  <= row_start ? d_mcp  : '0;
      park_mask <= row_start ? d_park : '0;
      if (row_start) begin
        if (drop) rule_err <= 1'b1;
        if (!drop && blk_mode == 2'b01 && fifteen_blk)
          nop_left <= CW'(NOP_CYCLES);
        else if (nop_left != '0)
          nop_left <= nop_left - 1'b1;
        if (pair_sel != pair_cand) begin
          pair_cand <= pair_sel;
          pair_pend <= 1'b1;
        end else if (pair_pend) begin
          pair_eff  <= pair_cand;
          pair_pend <= 1'b0;
        end
      end
    end
  end

  assert_issue_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    row_start |=> issue);
  assert_quiet_between_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !row_start |=> (!issue && clr_mask == '0 && mcp_mask == '0 && park_mask == '0));
  assert_one_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_mask));
  assert_one_kind_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({|clr_mask, |mcp_mask, |park_mask}) <= 1);
  assert_dead_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (row_start && fifteen_blk) |=> (!clr_mask[15] && !mcp_mask[15] && !park_mask[15]));
  assert_conflict_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (row_start && blk_mode == 2'b01 && write_busy && write_blk != blk_addr)
      |=> (clr_mask == '0 && rule_err));
  assert_err_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rule_err |=> rule_err);
endmodule

// File: tb/mirror_blk_decoder_tb.sv
module mirror_blk_decoder_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        row_start = 0;
  logic [1:0]  blk_mode = 0;
  logic [3:0]  blk_addr = 0;
  logic        pair_sel = 0;
  logic        write_busy = 0;
  logic [3:0]  write_blk = 0;
  logic        fifteen_blk = 0;
  logic [15:0] clr_mask, mcp_mask, park_mask;
  logic        issue, rule_err;

  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct {
    logic [15:0] c, m, p;
    logic        e;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  mirror_blk_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .row_start(row_start), .blk_mode(blk_mode),
    .blk_addr(blk_addr), .pair_sel(pair_sel), .write_busy(write_busy),
    .write_blk(write_blk), .fifteen_blk(fifteen_blk), .clr_mask(clr_mask),
    .mcp_mask(mcp_mask), .park_mask(park_mask), .issue(issue), .rule_err(rule_err)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (issue) begin
        checks++;
        if (q.size() == 0) begin
          fails++;
          $display("FAIL R7: unexpected issue pulse, got 1 expected 0");
        end else begin
          exp_t x;
          x = q.pop_front();
          if (clr_mask !== x.c || mcp_mask !== x.m || park_mask !== x.p || rule_err !== x.e) begin
            fails++;
            $display("FAIL %s: clr=%h mcp=%h park=%h err=%b expected clr=%h mcp=%h park=%h err=%b",
                     x.tag, clr_mask, mcp_mask, park_mask, rule_err, x.c, x.m, x.p, x.e);
          end
        end
      end else if (clr_mask != 0 || mcp_mask != 0 || park_mask != 0) begin
        checks++;
        fails++;
        $display("FAIL R7: masks between row cycles clr=%h mcp=%h park=%h expected 0", clr_mask, mcp_mask, park_mask);
      end
    end
  end

  task automatic row(input logic [1:0] md, input logic [3:0] ad, input logic ps,
                     input logic bz, input logic [3:0] wb, input logic fv,
                     input logic [15:0] ec, input logic [15:0] em, input logic [15:0] ep,
                     input logic ee, input string tag);
    exp_t x;
    @(negedge clk);
    blk_mode = md; blk_addr = ad; pair_sel = ps; write_busy = bz; write_blk = wb;
    fifteen_blk = fv; row_start = 1;
    x.c = ec; x.m = em; x.p = ep; x.e = ee; x.tag = tag;
    q.push_back(x);
    @(negedge clk);
    row_start = 0;
    #1;
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R7: issue missing one clock after strobe, got %0d pending expected 0", q.size());
      q.delete();
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    checks++;
    if (clr_mask != 0 || mcp_mask != 0 || park_mask != 0 || issue || rule_err) begin
      fails++;
      $display("FAIL R12: reset state clr=%h mcp=%h park=%h issue=%b err=%b expected all 0",
               clr_mask, mcp_mask, park_mask, issue, rule_err);
    end
  endtask

  initial begin
    do_reset();
    row(2'b00, 4'd5, 0, 0, 0, 0, 16'h0, 16'h0, 16'h0, 0, "R1 no-op");
    row(2'b01, 4'd3, 0, 0, 0, 0, 16'h0008, 16'h0, 16'h0, 0, "R2 clear");
    row(2'b10, 4'd9, 0, 0, 0, 0, 16'h0, 16'h0200, 16'h0, 0, "R3 pulse");
    row(2'b11, 4'b0011, 0, 0, 0, 0, 16'h0, 16'h00C0, 16'h0, 0, "R4 pair");
    row(2'b11, 4'b1001, 0, 0, 0, 0, 16'h0, 16'hFFFF, 16'h0, 0, "R6 global");
    row(2'b11, 4'b1110, 0, 0, 0, 0, 16'h0, 16'h0, 16'hFFFF, 0, "R6 park");
    row(2'b11, 4'b0011, 1, 0, 0, 0, 16'h0, 16'h00C0, 16'h0, 0, "R11 first strobe");
    row(2'b11, 4'b0011, 1, 0, 0, 0, 16'h0, 16'h00C0, 16'h0, 0, "R11 second strobe");
    row(2'b11, 4'b0011, 1, 0, 0, 0, 16'h0, 16'h00F0, 16'h0, 0, "R5 quad");
    row(2'b11, 4'b0010, 1, 0, 0, 0, 16'h0, 16'h00F0, 16'h0, 0, "R5 bit0 ignored");
    row(2'b11, 4'b0111, 1, 0, 0, 0, 16'h0, 16'hF000, 16'h0, 0, "R5 top group");
    row(2'b11, 4'b0000, 0, 0, 0, 0, 16'h0, 16'h000F, 16'h0, 0, "R11 glitch a");
    row(2'b11, 4'b0000, 1, 0, 0, 0, 16'h0, 16'h000F, 16'h0, 0, "R11 glitch b");
    row(2'b11, 4'b1000, 1, 0, 0, 0, 16'h0, 16'hFFFF, 16'h0, 0, "R6 global quad");
    row(2'b01, 4'd4, 1, 1, 4'd4, 0, 16'h0010, 16'h0, 16'h0, 0, "R10 clear own block");
    row(2'b10, 4'd6, 1, 1, 4'd1, 0, 16'h0, 16'h0040, 16'h0, 0, "R10 pulse during write");
    row(2'b10, 4'd15, 1, 0, 0, 1, 16'h0, 16'h0, 16'h0, 0, "R8 pulse block 15");
    row(2'b01, 4'd15, 1, 0, 0, 1, 16'h0, 16'h0, 16'h0, 0, "R8 clear block 15");
    row(2'b00, 4'd0, 1, 0, 0, 1, 16'h0, 16'h0, 16'h0, 0, "R9 no-op 1");
    row(2'b00, 4'd0, 1, 0, 0, 1, 16'h0, 16'h0, 16'h0, 0, "R9 no-op 2");
    row(2'b11, 4'b1000, 1, 0, 0, 1, 16'h0, 16'h7FFF, 16'h0, 0, "R8 global");
    row(2'b11, 4'b1100, 1, 0, 0, 1, 16'h0, 16'h0, 16'h7FFF, 0, "R8 park");
    row(2'b11, 4'b0110, 1, 0, 0, 1, 16'h0, 16'h7000, 16'h0, 0, "R8 quad");
    row(2'b01, 4'd1, 1, 0, 0, 1, 16'h0002, 16'h0, 16'h0, 0, "R9 clear");
    row(2'b00, 4'd0, 1, 0, 0, 1, 16'h0, 16'h0, 16'h0, 0, "R9 gap 1");
    row(2'b00, 4'd0, 1, 0, 0, 1, 16'h0, 16'h0, 16'h0, 0, "R9 gap 2");
    row(2'b10, 4'd2, 1, 0, 0, 1, 16'h0, 16'h0004, 16'h0, 0, "R9 after window");
    row(2'b01, 4'd1, 1, 0, 0, 0, 16'h0002, 16'h0, 16'h0, 0, "R9 clear 16-block");
    row(2'b10, 4'd3, 1, 0, 0, 0, 16'h0, 16'h0008, 16'h0, 0, "R9 no window 16-block");
    row(2'b01, 4'd0, 1, 0, 0, 1, 16'h0001, 16'h0, 16'h0, 0, "R9 clear again");
    row(2'b10, 4'd2, 1, 0, 0, 1, 16'h0, 16'h0, 16'h0, 1, "R9 drop in window");
    row(2'b00, 4'd0, 1, 0, 0, 1, 16'h0, 16'h0, 16'h0, 1, "R12 sticky");
    row(2'b10, 4'd2, 1, 0, 0, 1, 16'h0, 16'h0004, 16'h0, 1, "R9 window shortened");
    row(2'b01, 4'd2, 1, 1, 4'd5, 0, 16'h0, 16'h0, 16'h0, 1, "R10 conflicting clear");
    do_reset();
    row(2'b11, 4'b0001, 0, 0, 0, 0, 16'h0, 16'h000C, 16'h0, 0, "R11 pairing after reset");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule